// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block holds a CAN node in the bus-off condition and decides when the node may take part in bus traffic again. The error counters send a one-clock entry pulse when the node goes bus-off. From then on the block watches the received bit at each bit-time strobe. It counts runs of consecutive recessive bits and counts how many runs have completed. Once the required number of runs has been seen, it releases the node. At release it sends a one-clock rejoin pulse, which the error counters use to clear themselves.

A software configuration bit can hold the node in bus-off after the normal recovery condition has been met. The block captures that bit at the moment of bus-off entry. Setting the bit later in the same bus-off period does nothing. Clearing it while the hold is in force releases the node, and how the release works depends on whether the run count was already complete at that point. An enable input freezes recovery and clears both counters while it is low.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, `busOff`, `rejoinPulse` and `waitSoftware` are all low.
- R2: A `busOffEnter` pulse while `busOff` is low raises `busOff` at the next clock edge. A pulse while `busOff` is already high is ignored: the run counts in progress are kept.
- R3: A bit counts only on a clock where `bitStrobe` is high. `rxBit`=1 means recessive. A dominant bit (0) restarts the current run. Every 11 consecutive recessive strobed bits complete one run.
- R4: If `recoveryInhibit` was 0 at entry, `busOff` falls at the clock edge that samples the strobe completing the 128th run.
- R5: If `recoveryInhibit` was 1 at entry and is still 1, `busOff` stays high however long the bus stays recessive.
- R6: If `recoveryInhibit` was 1 at entry and is cleared before the 128th run completes, release happens exactly as in R4.
- R7: If `recoveryInhibit` is cleared after the 128th run has completed under a captured hold, the node rejoins on the strobe that completes 11 more consecutive recessive bits seen after the clear.
- R8: Setting `recoveryInhibit` during a bus-off period that was entered with it clear does not delay release.
- R9: `rejoinPulse` is high for exactly one clock, and it rises at the same edge at which `busOff` falls.
- R10: `waitSoftware` is high only while in bus-off, with 128 runs complete and the captured hold still in force.
- R11: While `enable` is low, no bits are counted, both counts clear, `busOff` holds its value and no rejoin occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low freezes recovery and clears the counts |
| bitStrobe | input | 1 | One-clock pulse once per bit time |
| rxBit | input | 1 | Received bit at the strobe, 1 = recessive |
| busOffEnter | input | 1 | Bus-off entry pulse from the error counters |
| recoveryInhibit | input | 1 | Software hold on automatic recovery |
| busOff | output | 1 | Node is in bus-off (including the final 11-bit resync) |
| rejoinPulse | output | 1 | One-clock pulse when the node leaves bus-off |
| waitSoftware | output | 1 | Recovery condition met, held by software |

## Verification
The bound checker checks on every cycle the shape of the rejoin pulse and its alignment with the falling edge of `busOff`, that entry from the active state always takes effect, that `waitSoftware` only appears during bus-off, that a hold in force is never released, and that no rejoin happens while the block is disabled. The exact strobe on which the node rejoins can only be shown by the bench's scenarios. Those scenarios cover the plain 128-run count, a run broken by a dominant bit, early and late clearing of the hold, setting the hold during recovery, a repeated entry pulse and a disable in the middle of recovery. For each of them the scoreboard compares the number of strobes counted since entry against the count worked out from the rules.

// File: rtl/can_boff_pkg.sv
package can_boff_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearCnt;   // force both counters to zero
    logic countEn;    // counting allowed this cycle
  } boffCtrlT;

  // Status from datapath to control
  typedef struct packed {
    logic runDone;    // this strobe completes a recessive run
    logic lastRun;    // this strobe completes the final required run
    logic condMet;    // all required runs have been seen
  } boffStatT;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_OFF    = 2'd1,
    ST_RESYNC = 2'd2
  } boffStateT;

endpackage

// File: rtl/boff_counters.sv
module boff_counters
  import can_boff_pkg::*;
#(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitStrobe,
  input  logic     rxBit,
  input  boffCtrlT ctrl,
  output boffStatT stat
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int SEQ_W = $clog2(SEQ_TARGET + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [SEQ_W-1:0] SEQ_FULL = SEQ_W'(SEQ_TARGET);
  localparam logic [SEQ_W-1:0] SEQ_PRE  = SEQ_W'(SEQ_TARGET - 1);

  logic [RUN_W-1:0] runCnt;
  logic [SEQ_W-1:0] seqCnt;
  logic             runEnd;

  assign runEnd = ctrl.countEn && bitStrobe && rxBit && (runCnt == RUN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      seqCnt <= '0;
    end else if (ctrl.clearCnt || !ctrl.countEn) begin
      runCnt <= '0;
      seqCnt <= '0;
    end else if (bitStrobe) begin
      if (!rxBit) begin
        runCnt <= '0;
      end else if (runCnt == RUN_LAST) begin
        runCnt <= '0;
        if (seqCnt != SEQ_FULL) seqCnt <= seqCnt + 1'b1;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stat.runDone = runEnd;
    stat.lastRun = runEnd && (seqCnt == SEQ_PRE);
    stat.condMet = (seqCnt == SEQ_FULL);
  end

endmodule

// File: rtl/boff_control.sv
module boff_control
  import can_boff_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     busOffEnter,
  input  logic     recoveryInhibit,
  input  boffStatT stat,
  output boffCtrlT ctrl,
  output logic     busOff,
  output logic     rejoinPulse,
  output logic     waitSoftware
);

  boffStateT state, nextState;
  logic      holdLatched, nextHold;
  logic      holdActive;
  logic      leave;

  assign holdActive = holdLatched && recoveryInhibit;

  always_comb begin
    nextState     = state;
    nextHold      = holdLatched;
    leave         = 1'b0;
    ctrl.clearCnt = 1'b0;
    ctrl.countEn  = enable && (state != ST_ACTIVE);
    unique case (state)
      ST_ACTIVE: begin
        if (busOffEnter) begin
          nextState     = ST_OFF;
          nextHold      = recoveryInhibit;
          ctrl.clearCnt = 1'b1;
        end
      end
      ST_OFF: begin
        if (enable && ((stat.lastRun && !holdActive) ||
                       (stat.condMet && !holdLatched))) begin
          leave = 1'b1;
        end else if (enable && stat.condMet && holdLatched && !recoveryInhibit) begin
          nextState     = ST_RESYNC;
          nextHold      = 1'b0;
          ctrl.clearCnt = 1'b1;
        end else if (!recoveryInhibit) begin
          nextHold = 1'b0;
        end
      end
      ST_RESYNC: begin
        if (enable && stat.runDone) leave = 1'b1;
      end
      default: nextState = ST_ACTIVE;
    endcase
    if (leave) begin
      nextState = ST_ACTIVE;
      nextHold  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_ACTIVE;
      holdLatched <= 1'b0;
      rejoinPulse <= 1'b0;
    end else begin
      state       <= nextState;
      holdLatched <= nextHold;
      rejoinPulse <= leave;
    end
  end

  assign busOff       = (state != ST_ACTIVE);
  assign waitSoftware = (state == ST_OFF) && stat.condMet && holdLatched;

endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
  import can_boff_pkg::*;
#(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic bitStrobe,
  input  logic rxBit,
  input  logic busOffEnter,
  input  logic recoveryInhibit,
  output logic busOff,
  output logic rejoinPulse,
  output logic waitSoftware
);

  boffCtrlT ctrlBus;
  boffStatT statBus;

  boff_counters #(
    .RUN_LEN   (RUN_LEN),
    .SEQ_TARGET(SEQ_TARGET)
  ) uCounters (
    .clk      (clk),
    .rstN     (rstN),
    .bitStrobe(bitStrobe),
    .rxBit    (rxBit),
    .ctrl     (ctrlBus),
    .stat     (statBus)
  );

  boff_control uControl (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .busOffEnter    (busOffEnter),
    .recoveryInhibit(recoveryInhibit),
    .stat           (statBus),
    .ctrl           (ctrlBus),
    .busOff         (busOff),
    .rejoinPulse    (rejoinPulse),
    .waitSoftware   (waitSoftware)
  );

endmodule

// File: rtl/can_busoff_recovery_chk.sv
module can_busoff_recovery_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic busOffEnter,
  input logic recoveryInhibit,
  input logic busOff,
  input logic rejoinPulse,
  input logic waitSoftware
);

  p_rejoin_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rejoinPulse |=> !rejoinPulse);

  p_rejoin_on_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    rejoinPulse |-> (!busOff && $past(busOff)));

  p_fall_has_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> rejoinPulse);

  p_entry_takes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && busOffEnter) |=> busOff);

  p_wait_in_busoff_r10: assert property (@(posedge clk) disable iff (!rstN)
    waitSoftware |-> busOff);

  p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (waitSoftware && recoveryInhibit) |=> busOff);

  p_no_rejoin_disabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rejoinPulse);

endmodule

bind can_busoff_recovery can_busoff_recovery_chk uChk (
  .clk            (clk),
  .rstN           (rstN),
  .enable         (enable),
  .busOffEnter    (busOffEnter),
  .recoveryInhibit(recoveryInhibit),
  .busOff         (busOff),
  .rejoinPulse    (rejoinPulse),
  .waitSoftware   (waitSoftware)
);

// File: tb/tb_can_busoff_recovery.sv
module tb_can_busoff_recovery;

  localparam int FULL = 11 * 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic bitStrobe = 1'b0;
  logic rxBit = 1'b1;
  logic busOffEnter = 1'b0;
  logic recoveryInhibit = 1'b0;
  logic busOff, rejoinPulse, waitSoftware;

  int compared = 0;
  int mismatched = 0;
  int strobesSince = 0;
  int expQ[$];
  logic prevPulse = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  can_busoff_recovery dut (
    .clk(clk), .rstN(rstN), .enable(enable), .bitStrobe(bitStrobe),
    .rxBit(rxBit), .busOffEnter(busOffEnter), .recoveryInhibit(recoveryInhibit),
    .busOff(busOff), .rejoinPulse(rejoinPulse), .waitSoftware(waitSoftware)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the expected strobe count on every rejoin (R9)
  always @(negedge clk) begin
    if (rstN) begin
      if (rejoinPulse) begin
        check(!prevPulse, "R9 pulse width", 2, 1);
        check(!busOff, "R9 busOff low with pulse", busOff, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected rejoin", strobesSince, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(strobesSince == e, "R4/R6/R7 rejoin strobe", strobesSince, e);
        end
      end
      prevPulse <= rejoinPulse;
    end
  end

  task automatic sendBits(input int n, input logic val);
    for (int i = 0; i < n; i++) begin
      bitStrobe = 1'b1;
      rxBit = val;
      strobesSince++;
      @(negedge clk);
      bitStrobe = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic enterBusOff(input logic inh);
    recoveryInhibit = inh;
    busOffEnter = 1'b1;
    @(negedge clk);
    busOffEnter = 1'b0;
    strobesSince = 0;
    check(busOff == 1'b1, "R2 entry", busOff, 1);
    @(negedge clk);
  endtask

  // Driver pushes the expected item, then checks the queue drained
  task automatic expectRejoin(input int cnt);
    expQ.push_back(cnt);
  endtask

  task automatic confirmDrained(input string req);
    @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
    check(busOff == 1'b0, req, busOff, 0);
    expQ.delete();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busOff == 0, "R1 busOff", busOff, 0);
    check(rejoinPulse == 0, "R1 rejoinPulse", rejoinPulse, 0);
    check(waitSoftware == 0, "R1 waitSoftware", waitSoftware, 0);

    // R4 plain automatic recovery
    enterBusOff(1'b0);
    expectRejoin(FULL);
    sendBits(FULL - 1, 1'b1);
    check(busOff == 1, "R4 still off before last run", busOff, 1);
    check(waitSoftware == 0, "R10 no wait in automatic mode", waitSoftware, 0);
    sendBits(1, 1'b1);
    confirmDrained("R4 rejoined");

    // R3 dominant bit restarts run; strobe-less cycles do not count
    enterBusOff(1'b0);
    expectRejoin(FULL + 11);
    sendBits(10, 1'b1);
    rxBit = 1'b1;
    repeat (30) @(negedge clk);
    sendBits(1, 1'b0);
    sendBits(FULL, 1'b1);
    confirmDrained("R3 dominant restart");

    // R5 hold in force, then R7 late clear needs 11 more
    enterBusOff(1'b1);
    sendBits(FULL + 20, 1'b1);
    check(busOff == 1, "R5 held in bus-off", busOff, 1);
    check(waitSoftware == 1, "R10 waitSoftware set", waitSoftware, 1);
    recoveryInhibit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(waitSoftware == 0, "R10 wait cleared after release", waitSoftware, 0);
    expectRejoin(FULL + 20 + 11);
    sendBits(10, 1'b1);
    check(busOff == 1, "R7 resync not done after 10", busOff, 1);
    sendBits(1, 1'b1);
    confirmDrained("R7 rejoined after 11 more");

    // R6 early clear behaves as automatic
    enterBusOff(1'b1);
    expectRejoin(FULL);
    sendBits(500, 1'b1);
    recoveryInhibit = 1'b0;
    @(negedge clk);
    sendBits(FULL - 500, 1'b1);
    confirmDrained("R6 early clear");

    // R8 setting hold during automatic recovery has no effect
    enterBusOff(1'b0);
    expectRejoin(FULL);
    sendBits(100, 1'b1);
    recoveryInhibit = 1'b1;
    @(negedge clk);
    sendBits(FULL - 100, 1'b1);
    confirmDrained("R8 late set ignored");
    recoveryInhibit = 1'b0;
    @(negedge clk);

    // R2 repeated entry pulse ignored
    enterBusOff(1'b0);
    expectRejoin(FULL);
    sendBits(700, 1'b1);
    busOffEnter = 1'b1;
    @(negedge clk);
    busOffEnter = 1'b0;
    @(negedge clk);
    sendBits(FULL - 700, 1'b1);
    confirmDrained("R2 second entry ignored");

    // R11 disable clears counts and freezes recovery
    enterBusOff(1'b0);
    sendBits(700, 1'b1);
    enable = 1'b0;
    @(negedge clk);
    sendBits(5, 1'b1);
    check(busOff == 1, "R11 busOff held while disabled", busOff, 1);
    enable = 1'b1;
    @(negedge clk);
    expectRejoin(705 + FULL);
    sendBits(FULL - 1, 1'b1);
    check(busOff == 1, "R11 counts restarted", busOff, 1);
    sendBits(1, 1'b1);
    confirmDrained("R11 recovery after enable");

    done = 1'b1;
    finishRun();
  end

endmodule